// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block works out the column address of every data beat in a read or write burst on a DDR memory interface. A controller gives it a start column, a one-cycle start pulse and a small mode word. The mode word sets the burst length to 2, 4 or 8 beats and picks sequential or interleaved ordering. The block takes a copy of the mode word and the start column on the start pulse. From the next cycle on it presents one column address per cycle with valid, first-beat and last-beat flags until the burst ends.

Addresses always stay inside the aligned window that the burst length defines. Only the low log2(BL) bits of the column change, and no carry reaches the bits above them. Sequential ordering adds the beat number to the low bits, with wrap-around inside the window. Interleaved ordering XORs the beat number into those bits. A mode word that holds a reserved burst-length code produces no beats and gives a one-cycle error flag instead. A start pulse that arrives during a burst cuts that burst short and starts the new one.

Top module: `ddr_burst_colgen`

## Requirements
- R1: While reset is asserted, and after it until the first start pulse, `beat_valid`, `beat_first`, `beat_last` and `cfg_error` are all low.
- R2: For a start pulse sampled at a rising edge with `cfg_mode[2:0]` equal to 3'b001, 3'b010 or 3'b011, `beat_valid` goes high from the next cycle and stays high for exactly 2, 4 or 8 consecutive cycles.
- R3: When `cfg_mode[3]` is 0 (sequential), beat k has low bits equal to (start low bits + k) modulo BL, where the low bits are bit 0 for BL 2, bits 1:0 for BL 4 and bits 2:0 for BL 8.
- R4: When `cfg_mode[3]` is 1 (interleaved), beat k has low log2(BL) bits equal to the start low bits XOR k.
- R5: On every beat, the column bits above the low log2(BL) bits equal those of the start column. No carry ever enters them.
- R6: `beat_first` is high only on beat 0 and `beat_last` only on beat BL-1. `beat_valid` is low in the cycle after the last beat unless a new burst starts.
- R7: A start pulse with a reserved length code (3'b000, or any code with bit 2 set) raises `cfg_error` for exactly one cycle after the start pulse, produces no beats and ends any burst in progress.
- R8: A legal start pulse during an active burst ends that burst. In the next cycle the block shows beat 0 of the new burst, starting at the new column.
- R9: The mode word is sampled only on the start pulse. Changing `cfg_mode` during a burst has no effect on its length, ordering or addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode | input | 4 | Mode word: bits 2:0 length code, bit 3 ordering |
| burst_start | input | 1 | One-cycle pulse that launches a burst |
| start_col | input | 9 | Start column of the burst |
| beat_col | output | 9 | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_first | output | 1 | Current beat is beat 0 |
| beat_last | output | 1 | Current beat is beat BL-1 |
| cfg_error | output | 1 | One-cycle flag for a reserved length code |

## Verification
The bench runs every legal length with both orderings, using start columns whose low bits sit at zero, in the middle of the window and at its top. This shows whether the wrap is inside the window and whether sequential and interleaved order can be told apart. A start column with set upper bits and low bits at the window's end checks that no carry leaks upward. The bench also issues reserved codes both from idle and during a burst, restarts in mid-burst and on the last beat, and changes the mode word during a burst. These cases separate a design that stores its configuration at the start from one that reads the live inputs.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int COL_W    = 9;
  localparam int MAX_LOG  = 3;
  localparam int LEN_W    = $clog2(MAX_LOG + 1);
  localparam int MODE_W   = 4;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;

  typedef struct packed {
    logic             legal;
    logic [LEN_W-1:0] len_log;
    order_e           order;
  } mode_cfg_t;
endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_cfg_t         cfg_o
);
  logic [2:0] len_code;

  assign len_code = mode_i[2:0];

  always_comb begin
    cfg_o.order   = order_e'(mode_i[3]);
    cfg_o.legal   = 1'b0;
    cfg_o.len_log = '0;
    if ((len_code != 3'd0) && (len_code[2] == 1'b0)) begin
      cfg_o.legal   = 1'b1;
      cfg_o.len_log = LEN_W'(len_code);
    end
  end
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
  import colgen_pkg::*;
(
  input  logic [COL_W-1:0]   base_i,
  input  logic [MAX_LOG-1:0] beat_i,
  input  logic [LEN_W-1:0]   len_log_i,
  input  order_e             order_i,
  output logic [COL_W-1:0]   col_o
);
  logic [MAX_LOG-1:0] low_seq;
  logic [MAX_LOG-1:0] low_ilv;
  logic [MAX_LOG-1:0] low_sel;

  assign low_seq = base_i[MAX_LOG-1:0] + beat_i;
  assign low_ilv = base_i[MAX_LOG-1:0] ^ beat_i;
  assign low_sel = (order_i == ORD_ILV) ? low_ilv : low_seq;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < MAX_LOG) begin : g_low
      assign col_o[i] = (LEN_W'(i) < len_log_i) ? low_sel[i] : base_i[i];
    end else begin : g_up
      assign col_o[i] = base_i[i];
    end
  end
endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [COL_W-1:0]   col_i,
  input  mode_cfg_t          cfg_i,
  output logic [COL_W-1:0]   base_o,
  output logic [MAX_LOG-1:0] beat_o,
  output logic [LEN_W-1:0]   len_log_o,
  output order_e             order_o,
  output logic               valid_o,
  output logic               first_o,
  output logic               last_o,
  output logic               err_o
);
  logic               active_q, active_d;
  logic [MAX_LOG-1:0] beat_q, beat_d;
  logic [COL_W-1:0]   base_q, base_d;
  logic [LEN_W-1:0]   len_q, len_d;
  order_e             ord_q, ord_d;
  logic               err_q, err_d;
  logic [MAX_LOG-1:0] last_idx;
  logic               at_end;
  logic               load_en;
  logic               step_en;

  assign last_idx = (MAX_LOG'(1) << len_q) - MAX_LOG'(1);
  assign at_end   = (beat_q == last_idx);
  assign load_en  = start_i && cfg_i.legal;
  assign step_en  = !start_i && active_q;

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    base_d   = base_q;
    len_d    = len_q;
    ord_d    = ord_q;
    err_d    = 1'b0;
    if (start_i) begin
      if (load_en) begin
        active_d = 1'b1;
        beat_d   = '0;
        base_d   = col_i;
        len_d    = cfg_i.len_log;
        ord_d    = cfg_i.order;
      end else begin
        active_d = 1'b0;
        err_d    = 1'b1;
      end
    end else if (step_en) begin
      if (at_end) active_d = 1'b0;
      else        beat_d   = beat_q + MAX_LOG'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      len_q    <= '0;
      ord_q    <= ORD_SEQ;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      err_q    <= err_d;
      if (load_en || step_en) beat_q <= beat_d;
      if (load_en) begin
        base_q <= base_d;
        len_q  <= len_d;
        ord_q  <= ord_d;
      end
    end
  end

  assign base_o    = base_q;
  assign beat_o    = beat_q;
  assign len_log_o = len_q;
  assign order_o   = ord_q;
  assign valid_o   = active_q;
  assign first_o   = active_q && (beat_q == '0);
  assign last_o    = active_q && at_end;
  assign err_o     = err_q;

  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !cfg_i.legal) |=> (err_o && !valid_o));
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cfg_i.legal) |=> (valid_o && first_o && base_o == $past(col_i)));
  // R6
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);
  // R2
  beat_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !start_i) |=> (valid_o && beat_o == $past(beat_o) + MAX_LOG'(1)));
endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
  import colgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              burst_start,
  input  logic [COL_W-1:0]  start_col,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_valid,
  output logic              beat_first,
  output logic              beat_last,
  output logic              cfg_error
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  mode_cfg_t          dec_cfg;
  logic [COL_W-1:0]   base;
  logic [MAX_LOG-1:0] beat;
  logic [LEN_W-1:0]   len_log;
  order_e             order;
  logic [COL_W-1:0]   win_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  colgen_mode_dec u_dec (
    .mode_i (cfg_mode),
    .cfg_o  (dec_cfg)
  );

  colgen_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (burst_start),
    .col_i     (start_col),
    .cfg_i     (dec_cfg),
    .base_o    (base),
    .beat_o    (beat),
    .len_log_o (len_log),
    .order_o   (order),
    .valid_o   (beat_valid),
    .first_o   (beat_first),
    .last_o    (beat_last),
    .err_o     (cfg_error)
  );

  colgen_addr u_addr (
    .base_i    (base),
    .beat_i    (beat),
    .len_log_i (len_log),
    .order_i   (order),
    .col_o     (beat_col)
  );

  assign win_mask = (COL_W'(1) << len_log) - COL_W'(1);

  // R5
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (beat_valid && !beat_first) |-> (((beat_col ^ $past(beat_col)) & ~win_mask) == '0));
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_error |-> !beat_valid);
endmodule

// File: tb/test_ddr_burst_colgen.sv
module test_ddr_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_mode = 4'd0;
  logic       burst_start = 1'b0;
  logic [8:0] start_col = 9'd0;
  logic [8:0] beat_col;
  logic       beat_valid, beat_first, beat_last, cfg_error;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  int q_col[$];
  int q_idx[$];
  int q_bl[$];
  int q_ilv[$];
  bit exp_err = 1'b0;
  string scen_tag = "";

  always #4 clk = ~clk;

  ddr_burst_colgen i_ddr_burst_colgen (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .burst_start(burst_start),
    .start_col(start_col), .beat_col(beat_col), .beat_valid(beat_valid),
    .beat_first(beat_first), .beat_last(beat_last), .cfg_error(cfg_error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model: queue of beats to be shown, front = current beat
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q_col.delete(); q_idx.delete(); q_bl.delete(); q_ilv.delete();
      exp_err = 1'b0;
    end else begin
      exp_err = 1'b0;
      if (burst_start) begin
        int code;
        q_col.delete(); q_idx.delete(); q_bl.delete(); q_ilv.delete();
        code = int'(cfg_mode[2:0]);
        if (code >= 1 && code <= 3) begin
          int bl, lo, hi;
          bl = 1 << code;
          lo = int'(start_col) % bl;
          hi = int'(start_col) - lo;
          for (int k = 0; k < bl; k++) begin
            q_col.push_back(cfg_mode[3] ? hi + (lo ^ k) : hi + ((lo + k) % bl));
            q_idx.push_back(k);
            q_bl.push_back(bl);
            q_ilv.push_back(int'(cfg_mode[3]));
          end
        end else begin
          exp_err = 1'b1;
        end
      end else if (q_col.size() > 0) begin
        void'(q_col.pop_front()); void'(q_idx.pop_front());
        void'(q_bl.pop_front());  void'(q_ilv.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      bit ev;
      ev = (q_col.size() > 0);
      check(beat_valid == ev, scen_tag != "" ? scen_tag : "R2", beat_valid, ev);
      check(cfg_error == exp_err, "R7", cfg_error, exp_err);
      if (ev && beat_valid) begin
        int bl, e;
        string t;
        bl = q_bl[0];
        e  = q_col[0];
        check(beat_first == (q_idx[0] == 0), "R6", beat_first, q_idx[0] == 0);
        check(beat_last == (q_idx[0] == bl - 1), "R6", beat_last, q_idx[0] == bl - 1);
        if ((int'(beat_col) / bl) != (e / bl)) t = "R5";
        else if (scen_tag != "") t = scen_tag;
        else t = (q_ilv[0] != 0) ? "R4" : "R3";
        check(int'(beat_col) == e, t, beat_col, e);
      end
    end
  end

  task automatic launch(input logic [3:0] m, input logic [8:0] c);
    @(negedge clk);
    cfg_mode = m; start_col = c; burst_start = 1'b1;
    @(negedge clk);
    burst_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({beat_valid, beat_first, beat_last, cfg_error} == 4'b0, "R1",
          {beat_valid, beat_first, beat_last, cfg_error}, 0);
    rst_n = 1'b1;
    idle(4);
    check({beat_valid, beat_first, beat_last, cfg_error} == 4'b0, "R1",
          {beat_valid, beat_first, beat_last, cfg_error}, 0);
    chk_en = 1'b1;

    // every length and ordering across start columns
    for (int o = 0; o < 2; o++) begin
      for (int c = 1; c <= 3; c++) begin
        launch({o[0], c[2:0]}, 9'h000); idle(9);
        launch({o[0], c[2:0]}, 9'h0A5); idle(9);
        launch({o[0], c[2:0]}, 9'h1FF); idle(9);
        launch({o[0], c[2:0]}, 9'h0D6); idle(9);
      end
    end

    // R7 reserved codes from idle
    launch(4'b0000, 9'h011); idle(3);
    launch(4'b0100, 9'h011); idle(3);
    launch(4'b1111, 9'h011); idle(3);
    launch(4'b1101, 9'h011); idle(3);
    // R7 reserved code aborts a running burst
    launch(4'b0011, 9'h033); idle(2);
    launch(4'b0110, 9'h044); idle(10);

    // R8 restart mid-burst and on the last beat
    scen_tag = "R8";
    launch(4'b0011, 9'h10B); idle(2);
    launch(4'b1010, 9'h0C7); idle(8);
    launch(4'b0001, 9'h00F);
    launch(4'b1011, 9'h1F3); idle(10);

    // R9 mode word changed mid-burst
    scen_tag = "R9";
    launch(4'b1011, 9'h16E);
    cfg_mode = 4'b0001; idle(2);
    cfg_mode = 4'b0000; idle(8);
    launch(4'b0001, 9'h005);
    cfg_mode = 4'b1011; idle(5);
    scen_tag = "";

    chk_en = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule